// File: doc/BRIEF.md
# IO address translation unit

This block maps 32-bit device virtual addresses onto a 41-bit physical space for a DMA-capable bus. Translation uses a flat table in system memory with one 64-bit entry per 8 KB page. The table covers a window that always ends at the top of the 32-bit space. A 3-bit size code sets how far the window reaches downward, from 8 MB up to 1 GB.

Software sets up the unit through a write-only register port. Select 0 is control, select 1 is the table base and select 2 is the flush register. A device then presents one request at a time through a valid/ready handshake.

For each request the unit does three things in order:
- It checks the address against the window.
- It looks in a one-entry cache that holds the last valid entry it fetched.
- On a miss, it reads the entry through a single read port to table memory.

The response is a one-cycle done pulse. It carries either the physical address with the cacheable and streamable attributes, or a fault code.

Top module: `iova_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_done and mem_rd_en are 0, translation is disabled and the cache is empty.
- R2: In a control write (select 0), bit 0 enables translation and bits 18:16 give the size code n. The other control bits, including bit 1 (diagnostic) and bit 2 (page size), do not change any translation result. Select 1 loads the table base from data bits 40:13.
- R3: The window base is 2^32 − 8 MB·2^n. If translation is disabled, or the address is below the base, the request completes one cycle after acceptance with fault kind 1 (range), rsp_fault high and no memory read.
- R4: The table index is (address − base) >> 13. On a miss, mem_rd_en pulses for one cycle in the cycle after acceptance, with mem_rd_addr = table base + index·8.
- R5: In an entry, bit 63 is valid, bit 60 is streamable, bit 4 is cacheable and bit 1 is writable, and bits 40:13 hold the physical page number. A successful response gives rsp_pa = {page number, address[12:0]}, with fault kind 0.
- R6: An entry with bit 63 clear gives fault kind 2 (invalid). A write request to an entry with bit 1 clear gives fault kind 3 (write protect). A read of that same entry succeeds.
- R7: Every faulting response has rsp_pa, rsp_cacheable and rsp_streamable all 0.
- R8: After a miss, rsp_done rises in the cycle after mem_rd_valid.
- R9: req_ready is high only when no request is in flight. It stays low from the acceptance of a miss until its response.
- R10: A request to the same virtual page as the cached entry completes one cycle after acceptance with no memory read. Entries with bit 63 clear are never cached, and fetching one leaves the cache as it was.
- R11: A write to select 2 (any data), select 0 or select 1 empties the cache, so the next request refetches its entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 control, 1 table base, 2 flush |
| reg_wr_data | input | 64 | Register write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_va | input | 32 | Device virtual address |
| req_write | input | 1 | Request is a write access |
| mem_rd_en | output | 1 | Table read strobe (one cycle) |
| mem_rd_addr | output | 41 | Byte address of the entry |
| mem_rd_valid | input | 1 | Table read data valid |
| mem_rd_data | input | 64 | Entry read from the table |
| rsp_done | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_fault_kind | output | 2 | 0 none, 1 range, 2 invalid, 3 write protect |
| rsp_pa | output | 41 | Translated physical address |
| rsp_cacheable | output | 1 | Page is cacheable |
| rsp_streamable | output | 1 | Page is streamable |

## Verification
Range faults and cache hits respond exactly one cycle after the accepting edge. Misses respond one cycle after mem_rd_valid, which makes their latency one plus the memory latency. The table read itself appears in the cycle right after acceptance.

The bench's behavioural model predicts the due cycle of every request from these rules, using the memory latency it programmed into its own table responder. It then compares rsp_done on every cycle up to that point: low before the due cycle, high at it. Fields and the read count are compared only at the due cycle. Memory latencies of one and three cycles are both used, so the miss timing is not tied to a single delay.

// File: rtl/iova_pkg.sv
`timescale 1ns/1ps
package iova_pkg;
    localparam int VA_W          = 32;
    localparam int PA_W          = 41;
    localparam int PG_SHIFT      = 13;
    localparam int ENT_W         = 64;
    localparam int SZ_W          = 3;
    localparam int MIN_WIN_LOG2  = 23;
    localparam int ENT_B_LOG2    = 3;
    localparam int REG_SEL_W     = 2;
    localparam int PPN_W         = PA_W - PG_SHIFT;
    localparam int VPN_W         = VA_W - PG_SHIFT;
    localparam int IDX_W         = MIN_WIN_LOG2 + (2**SZ_W - 1) - PG_SHIFT;

    // control register fields
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_SIZE_LO   = 16;

    // entry fields
    localparam int PTE_V_BIT     = 63;
    localparam int PTE_S_BIT     = 60;
    localparam int PTE_C_BIT     = 4;
    localparam int PTE_W_BIT     = 1;

    typedef logic [REG_SEL_W-1:0] regsel_t;
    localparam regsel_t SEL_CTL   = 2'd0;
    localparam regsel_t SEL_BASE  = 2'd1;
    localparam regsel_t SEL_FLUSH = 2'd2;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_RANGE   = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_WPROT   = 2'd3
    } fault_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } st_e;

    typedef struct packed {
        logic             valid;
        logic             stream;
        logic             cache;
        logic             write;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    function automatic pte_t pte_decode(input logic [ENT_W-1:0] raw);
        pte_t p;
        p.valid  = raw[PTE_V_BIT];
        p.stream = raw[PTE_S_BIT];
        p.cache  = raw[PTE_C_BIT];
        p.write  = raw[PTE_W_BIT];
        p.ppn    = raw[PA_W-1:PG_SHIFT];
        return p;
    endfunction
endpackage

// File: rtl/iova_window.sv
`timescale 1ns/1ps
module iova_window
    import iova_pkg::*;
(
    input  logic [SZ_W-1:0]  size_code,
    input  logic [VA_W-1:0]  va,
    output logic             in_win,
    output logic [IDX_W-1:0] idx
);
    logic [VA_W-1:0] base;
    logic [VA_W-1:0] off;
    logic            unused_off;

    // window ends at the top of the space and doubles downward per size step
    assign base       = {VA_W{1'b1}} << (MIN_WIN_LOG2 + int'(size_code));
    assign in_win     = (va >= base);
    assign off        = va - base;
    assign idx        = off[PG_SHIFT +: IDX_W];
    assign unused_off = ^{off[VA_W-1:PG_SHIFT+IDX_W], off[PG_SHIFT-1:0]};
endmodule

// File: rtl/iova_entry_chk.sv
`timescale 1ns/1ps
module iova_entry_chk
    import iova_pkg::*;
(
    input  pte_t                pte,
    input  logic                is_write,
    input  logic [PG_SHIFT-1:0] pg_off,
    output fault_e              kind,
    output logic [PA_W-1:0]     pa,
    output logic                cacheable,
    output logic                streamable
);
    always_comb begin
        kind       = FLT_NONE;
        pa         = '0;
        cacheable  = 1'b0;
        streamable = 1'b0;
        if (!pte.valid) begin
            kind = FLT_INVALID;
        end else if (is_write && !pte.write) begin
            kind = FLT_WPROT;
        end else begin
            pa         = {pte.ppn, pg_off};
            cacheable  = pte.cache;
            streamable = pte.stream;
        end
    end
endmodule

// File: rtl/iova_last_cache.sv
`timescale 1ns/1ps
module iova_last_cache
    import iova_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fill,
    input  logic [VPN_W-1:0] fill_tag,
    input  pte_t             fill_pte,
    input  logic [VPN_W-1:0] look_tag,
    output logic             hit,
    output pte_t             hit_pte
);
    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] tag;
        pte_t             pte;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (fill) begin
            line_d.vld = 1'b1;
            line_d.tag = fill_tag;
            line_d.pte = fill_pte;
        end
        if (flush) begin
            line_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign hit     = line_q.vld && (line_q.tag == look_tag);
    assign hit_pte = line_q.pte;
endmodule

// File: rtl/iova_xlate.sv
`timescale 1ns/1ps
module iova_xlate
    import iova_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [REG_SEL_W-1:0] reg_wr_sel,
    input  logic [ENT_W-1:0]     reg_wr_data,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VA_W-1:0]      req_va,
    input  logic                 req_write,
    output logic                 mem_rd_en,
    output logic [PA_W-1:0]      mem_rd_addr,
    input  logic                 mem_rd_valid,
    input  logic [ENT_W-1:0]     mem_rd_data,
    output logic                 rsp_done,
    output logic                 rsp_fault,
    output logic [1:0]           rsp_fault_kind,
    output logic [PA_W-1:0]      rsp_pa,
    output logic                 rsp_cacheable,
    output logic                 rsp_streamable
);
    typedef struct packed {
        st_e                 st;
        logic                en;
        logic [SZ_W-1:0]     size;
        logic [PPN_W-1:0]    tbase;
        logic [VPN_W-1:0]    pend_tag;
        logic [PG_SHIFT-1:0] pend_off;
        logic                pend_wr;
        logic                mem_en;
        logic [PA_W-1:0]     mem_addr;
        logic                done;
        fault_e              kind;
        logic [PA_W-1:0]     pa;
        logic                c;
        logic                s;
    } state_t;

    state_t st_d, st_q;

    logic                win_ok;
    logic [IDX_W-1:0]    win_idx;
    logic                c_hit;
    pte_t                c_pte;
    logic                c_fill;
    logic                c_flush;
    logic                fetching;
    pte_t                chk_pte;
    logic                chk_wr;
    logic [PG_SHIFT-1:0] chk_off;
    fault_e              chk_kind;
    logic [PA_W-1:0]     chk_pa;
    logic                chk_c;
    logic                chk_s;
    logic                ctl_en_w;
    logic [SZ_W-1:0]     ctl_size_w;
    logic                unused_bits;

    iova_window u_window (
        .size_code (st_q.size),
        .va        (req_va),
        .in_win    (win_ok),
        .idx       (win_idx)
    );

    iova_last_cache u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (c_flush),
        .fill     (c_fill),
        .fill_tag (st_q.pend_tag),
        .fill_pte (chk_pte),
        .look_tag (req_va[VA_W-1:PG_SHIFT]),
        .hit      (c_hit),
        .hit_pte  (c_pte)
    );

    // one checker serves both the cached entry and the fetched one
    assign fetching = (st_q.st == ST_FETCH);
    assign chk_pte  = fetching ? pte_decode(mem_rd_data) : c_pte;
    assign chk_wr   = fetching ? st_q.pend_wr  : req_write;
    assign chk_off  = fetching ? st_q.pend_off : req_va[PG_SHIFT-1:0];

    iova_entry_chk u_chk (
        .pte        (chk_pte),
        .is_write   (chk_wr),
        .pg_off     (chk_off),
        .kind       (chk_kind),
        .pa         (chk_pa),
        .cacheable  (chk_c),
        .streamable (chk_s)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.mem_en = 1'b0;
        c_fill      = 1'b0;
        c_flush     = reg_wr_en && ((reg_wr_sel == SEL_CTL) ||
                                    (reg_wr_sel == SEL_BASE) ||
                                    (reg_wr_sel == SEL_FLUSH));
        if (reg_wr_en) begin
            case (reg_wr_sel)
                SEL_CTL: begin
                    st_d.en   = reg_wr_data[CTL_EN_BIT];
                    st_d.size = reg_wr_data[CTL_SIZE_LO +: SZ_W];
                end
                SEL_BASE: st_d.tbase = reg_wr_data[PA_W-1:PG_SHIFT];
                default: ;
            endcase
        end
        case (st_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!st_q.en || !win_ok) begin
                        st_d.done = 1'b1;
                        st_d.kind = FLT_RANGE;
                        st_d.pa   = '0;
                        st_d.c    = 1'b0;
                        st_d.s    = 1'b0;
                    end else if (c_hit) begin
                        st_d.done = 1'b1;
                        st_d.kind = chk_kind;
                        st_d.pa   = chk_pa;
                        st_d.c    = chk_c;
                        st_d.s    = chk_s;
                    end else begin
                        st_d.st       = ST_FETCH;
                        st_d.mem_en   = 1'b1;
                        st_d.mem_addr = {st_q.tbase, {PG_SHIFT{1'b0}}}
                                      + PA_W'({win_idx, {ENT_B_LOG2{1'b0}}});
                        st_d.pend_tag = req_va[VA_W-1:PG_SHIFT];
                        st_d.pend_off = req_va[PG_SHIFT-1:0];
                        st_d.pend_wr  = req_write;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_rd_valid) begin
                    st_d.st   = ST_IDLE;
                    st_d.done = 1'b1;
                    st_d.kind = chk_kind;
                    st_d.pa   = chk_pa;
                    st_d.c    = chk_c;
                    st_d.s    = chk_s;
                    c_fill    = chk_pte.valid;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready      = (st_q.st == ST_IDLE);
    assign mem_rd_en      = st_q.mem_en;
    assign mem_rd_addr    = st_q.mem_addr;
    assign rsp_done       = st_q.done;
    assign rsp_fault      = (st_q.kind != FLT_NONE);
    assign rsp_fault_kind = st_q.kind;
    assign rsp_pa         = st_q.pa;
    assign rsp_cacheable  = st_q.c;
    assign rsp_streamable = st_q.s;
    assign ctl_en_w       = st_q.en;
    assign ctl_size_w     = st_q.size;
    assign unused_bits    = ^{reg_wr_data[ENT_W-1:PA_W], reg_wr_data[PG_SHIFT-1:CTL_EN_BIT+1]};
endmodule

// File: rtl/iova_xlate_chk.sv
`timescale 1ns/1ps
module iova_xlate_chk
    import iova_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_va,
    input logic            ctl_en,
    input logic [SZ_W-1:0] ctl_size,
    input logic            mem_rd_en,
    input logic [PA_W-1:0] mem_rd_addr,
    input logic            mem_rd_valid,
    input logic            rsp_done,
    input logic [1:0]      rsp_fault_kind,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_cacheable,
    input logic            rsp_streamable
);
    logic [VA_W-1:0] low_edge;
    assign low_edge = {VA_W{1'b1}} << (MIN_WIN_LOG2 + int'(ctl_size));

    AST_RANGE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (!ctl_en || req_va < low_edge))
        |=> (!mem_rd_en && rsp_done && rsp_fault_kind == 2'd1)); // R3

    AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_fault_kind != 2'd0)
        |-> (rsp_pa == '0 && !rsp_cacheable && !rsp_streamable)); // R7

    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_rd_addr[ENT_B_LOG2-1:0] == '0)); // R4

    AST_FETCH_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> $past(req_valid && req_ready)); // R4

    AST_BUSY_WHILE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready); // R9

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ($past(req_valid && req_ready) || $past(mem_rd_valid))); // R8
endmodule

bind iova_xlate iova_xlate_chk u_xlate_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_va         (req_va),
    .ctl_en         (ctl_en_w),
    .ctl_size       (ctl_size_w),
    .mem_rd_en      (mem_rd_en),
    .mem_rd_addr    (mem_rd_addr),
    .mem_rd_valid   (mem_rd_valid),
    .rsp_done       (rsp_done),
    .rsp_fault_kind (rsp_fault_kind),
    .rsp_pa         (rsp_pa),
    .rsp_cacheable  (rsp_cacheable),
    .rsp_streamable (rsp_streamable)
);

// File: tb/iova_xlate_bench.sv
`timescale 1ns/1ps
module iova_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic [1:0]  reg_wr_sel;
    logic [63:0] reg_wr_data;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_va;
    logic        req_write;
    logic        mem_rd_en;
    logic [40:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [63:0] mem_rd_data;
    logic        rsp_done;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_kind;
    logic [40:0] rsp_pa;
    logic        rsp_cacheable;
    logic        rsp_streamable;

    always #2.5 clk = ~clk;

    iova_xlate u_iova_xlate (.*);

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // table memory model
    logic [63:0] tbl [logic [40:0]];
    int          mem_lat = 1;
    int          fetch_cnt = 0;
    logic [40:0] last_fetch = '0;

    // reference state
    bit          r_en = 0;
    int          r_size = 0;
    longint      r_tbase = 0;
    bit          c_vld = 0;
    longint      c_tag = 0;
    logic [63:0] c_raw = '0;

    function automatic logic [63:0] rd_tbl(input logic [40:0] a);
        if (tbl.exists(a)) return tbl[a];
        return 64'd0;
    endfunction

    function automatic logic [63:0] mk_pte(input bit v, input bit s, input bit c,
                                           input bit w, input longint ppn);
        logic [63:0] r = '0;
        r[63]    = v;
        r[60]    = s;
        r[4]     = c;
        r[1]     = w;
        r[40:13] = ppn[27:0];
        return r;
    endfunction

    task automatic check(input string rq, input string what,
                         input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // table responder
    initial begin
        mem_rd_valid = 1'b0;
        mem_rd_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_rd_en) begin
                fetch_cnt++;
                last_fetch = mem_rd_addr;
                repeat (mem_lat - 1) @(negedge clk);
                mem_rd_data  = rd_tbl(last_fetch);
                mem_rd_valid = 1'b1;
                @(negedge clk);
                mem_rd_valid = 1'b0;
            end
        end
    end

    task automatic reg_write(input logic [1:0] sel, input logic [63:0] data);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = sel;
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
        case (sel)
            2'd0: begin r_en = data[0]; r_size = int'(data[18:16]); end
            2'd1: r_tbase = longint'(data[40:13]) << 13;
            default: ;
        endcase
        c_vld = 0;
    endtask

    task automatic xlate(input longint va, input bit wr, input string rq);
        longint      base;
        longint      idx;
        logic [40:0] e_addr;
        logic [63:0] raw;
        bit          hit;
        bit          e_fetch;
        int          lat;
        int          e_kind;
        longint      e_pa;
        bit          e_c;
        bit          e_s;
        int          f0;
        base    = 64'h1_0000_0000 - (longint'(1) << (23 + r_size));
        e_addr  = '0;
        e_fetch = 0;
        e_pa    = 0;
        e_c     = 0;
        e_s     = 0;
        lat     = 1;
        if (!r_en || va < base) begin
            e_kind = 1;
        end else begin
            idx     = (va - base) >> 13;
            e_addr  = 41'(r_tbase + idx * 8);
            hit     = c_vld && (c_tag == (va >> 13));
            raw     = hit ? c_raw : rd_tbl(e_addr);
            e_fetch = !hit;
            lat     = hit ? 1 : 1 + mem_lat;
            if (!raw[63])            e_kind = 2;
            else if (wr && !raw[1])  e_kind = 3;
            else begin
                e_kind = 0;
                e_pa   = (longint'(raw[40:13]) << 13) | (va & 64'h1FFF);
                e_c    = raw[4];
                e_s    = raw[60];
            end
            if (!hit && raw[63]) begin
                c_vld = 1;
                c_tag = va >> 13;
                c_raw = raw;
            end
        end
        @(negedge clk);
        check("R9", "ready before request", longint'(req_ready), 1);
        req_valid = 1'b1;
        req_va    = va[31:0];
        req_write = wr;
        f0        = fetch_cnt;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= lat; k++) begin
            if (k > 1) @(negedge clk);
            if (k < lat) begin
                check(rq, "early done", longint'(rsp_done), 0);
                check("R9", "ready during fetch", longint'(req_ready), 0);
            end else begin
                check(e_fetch ? "R8" : rq, "done at due cycle", longint'(rsp_done), 1);
                #1;
                check(rq, "fault kind", longint'(rsp_fault_kind), longint'(e_kind));
                check(rq, "fault flag", longint'(rsp_fault), longint'(e_kind != 0));
                check(e_kind != 0 ? "R7" : rq, "pa", longint'(rsp_pa), e_pa);
                check(e_kind != 0 ? "R7" : "R5", "cacheable", longint'(rsp_cacheable), longint'(e_c));
                check(e_kind != 0 ? "R7" : "R5", "streamable", longint'(rsp_streamable), longint'(e_s));
                check(e_fetch ? "R4" : "R10", "table reads", longint'(fetch_cnt - f0),
                      longint'(e_fetch));
                if (e_fetch) check("R4", "fetch address", longint'(last_fetch), longint'(e_addr));
            end
        end
    endtask

    localparam logic [40:0] TBASE = 41'h0A_5000_0000;

    initial begin
        rst_n       = 1'b0;
        reg_wr_en   = 1'b0;
        reg_wr_sel  = '0;
        reg_wr_data = '0;
        req_valid   = 1'b0;
        req_va      = '0;
        req_write   = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", longint'(req_ready), 1);
        check("R1", "done after reset", longint'(rsp_done), 0);
        check("R1", "fetch after reset", longint'(mem_rd_en), 0);

        // disabled after reset
        xlate(64'hFF80_2000, 0, "R1");
        xlate(64'hFFFF_E000, 0, "R3");

        // table contents for size 0
        tbl[TBASE + 41'd40] = mk_pte(1, 0, 1, 1, 64'h0ABCDE);
        tbl[TBASE + 41'd48] = mk_pte(1, 1, 0, 0, 64'h0000123);
        tbl[TBASE + 41'd56] = 64'h0000_0000_0000_0012;
        reg_write(2'd1, 64'(TBASE));
        reg_write(2'd0, 64'h0000_0001);

        xlate(64'hFF80_0000 + 5 * 8192 + 64'h123, 0, "R5");
        xlate(64'hFF80_0000 + 5 * 8192 + 64'h1FFF, 1, "R10");
        xlate(64'hFF7F_FFFF, 0, "R3");
        xlate(64'hFF80_0000 + 6 * 8192 + 64'h10, 1, "R6");
        xlate(64'hFF80_0000 + 6 * 8192 + 64'h20, 0, "R6");
        xlate(64'hFF80_0000 + 7 * 8192, 0, "R6");
        xlate(64'hFF80_0000 + 7 * 8192 + 8, 0, "R10");
        xlate(64'hFF80_0000 + 6 * 8192 + 64'h30, 0, "R10");

        reg_write(2'd2, 64'h0);
        xlate(64'hFF80_0000 + 6 * 8192 + 64'h40, 0, "R11");

        mem_lat = 3;
        xlate(64'hFF80_0000 + 5 * 8192 + 64'h8, 0, "R8");
        xlate(64'hFF80_0000 + 5 * 8192 + 64'hC, 0, "R10");

        // size 7, with the diagnostic and page-size bits set
        tbl[TBASE]                 = mk_pte(1, 0, 0, 1, 64'h7654321);
        tbl[TBASE + 41'h0F_FFF8]   = mk_pte(1, 1, 1, 1, 64'h0000F00);
        reg_write(2'd0, 64'h0007_0007);
        xlate(64'hC000_0000 + 64'h44, 0, "R2");
        xlate(64'hFFFF_E000 + 64'h10, 1, "R4");
        xlate(64'hBFFF_FFFF, 0, "R3");

        mem_lat = 1;
        // size 3
        tbl[TBASE + 41'd16] = mk_pte(1, 0, 1, 0, 64'h0033333);
        reg_write(2'd0, 64'h0003_0001);
        xlate(64'hFC00_4000 + 64'h5, 0, "R4");
        xlate(64'hFC00_4000 + 64'h6, 0, "R10");
        reg_write(2'd1, 64'(TBASE));
        xlate(64'hFC00_4000 + 64'h7, 0, "R11");
        xlate(64'hFBFF_E000, 0, "R3");

        reg_write(2'd0, 64'h0003_0000);
        xlate(64'hFC00_4000, 0, "R3");

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule